// File: doc/BRIEF.md
# Per-Bit Configurable GPIO Port

This block is an 8-bit general-purpose I/O port controlled over a small register bus. Each bit of the port is set up on its own as an input or an output. The block drives three signals per bit to the pad ring: output enable, output data and pull-up enable. It also samples the pad input level through a synchroniser, and the sampled value can be read back over the bus.

There are three registers. A direction register selects output (1) or input (0) for each bit. An output register has two jobs. On an output bit it gives the level driven onto the pad. On an input bit it turns the pull-up on (1) or leaves the pad floating (0). A read-only pin register returns the synchronised pad level for every bit, including bits that the port itself drives. A value written to an output bit therefore reads back from the pad once it has passed the synchroniser.

Top module: `gpio_port`

## Requirements
- R1: A synchronous active-high reset clears the direction and output registers. After reset `pad_oe`, `pad_do` and `pad_pu` are all zero, and reads of the direction and output registers return 0.
- R2: The register addresses are 0 for pin, 1 for direction and 2 for output/pull-up. A write with `wr_en` high at a rising clock edge loads `wr_data` into the addressed register. `rd_data` shows the register selected by `addr` combinationally.
- R3: `pad_oe[i]` equals direction bit i.
- R4: When direction bit i is 1, `pad_do[i]` equals output bit i. When direction bit i is 0, `pad_do[i]` is 0.
- R5: `pad_pu[i]` is 1 exactly when direction bit i is 0 and output bit i is 1. A bit never has its pull-up and its output enable on together.
- R6: The pin register returns the pad level after it has passed SYNC_STAGES flip-flops. A pad change made between clock edges is visible after SYNC_STAGES rising edges and not before.
- R7: Writes to address 0 (pin) and to address 3 change no register. Address 3 reads as 0.
- R8: Direction and output bits act independently, so any mix of inputs, pulled-up inputs and outputs can exist in the port at once.
- R9: On an output bit, the pin register reads back the driven level. With SYNC_STAGES=1 the level appears one clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Combinational read data |
| pad_in | input | WIDTH | Level seen at the pads |
| pad_oe | output | WIDTH | Pad output enable per bit |
| pad_do | output | WIDTH | Pad output data per bit |
| pad_pu | output | WIDTH | Pad pull-up enable per bit |

## Verification
The bench builds two copies of the port with WIDTH=8. One uses SYNC_STAGES=2, which shows the full synchroniser delay and whether a pad change is visible too early. The other uses SYNC_STAGES=1, which makes the single-clock loopback of a driven output directly observable. Each copy has a pad model that loops the output back on enabled bits, applies the pull-up on pulled-up inputs and otherwise takes an external level. This lets the bench read the true pad level back through the pin register for every bit configuration.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PIN = 2'd0,
    REG_DIR = 2'd1,
    REG_OUT = 2'd2,
    REG_RSV = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  localparam int CNT_W = $clog2(SYNC_STAGES + 2) + 1;

  logic [WIDTH-1:0] stg [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_out = stg[SYNC_STAGES-1];

  // checker state: number of edges the input has held its value
  logic [WIDTH-1:0] chk_prev;
  logic [CNT_W-1:0] chk_cnt;
  always_ff @(posedge clk) begin
    chk_prev <= d_in;
    if (rst || d_in != chk_prev) chk_cnt <= '0;
    else if (chk_cnt <= CNT_W'(SYNC_STAGES)) chk_cnt <= chk_cnt + 1'b1;
  end

  // R6
  sync_settle_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_cnt > CNT_W'(SYNC_STAGES)) |-> (q_out == chk_prev));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [WIDTH-1:0]  pin_val,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_en) begin
      if (addr == REG_DIR) dir_q <= wr_data;
      if (addr == REG_OUT) out_q <= wr_data;
    end
  end

  always_comb begin
    case (addr)
      REG_PIN: rd_data = pin_val;
      REG_DIR: rd_data = dir_q;
      REG_OUT: rd_data = out_q;
      default: rd_data = '0;
    endcase
  end

  // R2
  dir_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_DIR) |=> (dir_q == $past(wr_data)));

  // R2
  out_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_OUT) |=> (out_q == $past(wr_data)));

  // R7
  ro_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == REG_PIN || addr == REG_RSV)) |=> ($stable(dir_q) && $stable(out_q)));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_do,
  output logic [WIDTH-1:0] pad_pu
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign pad_oe[b] = dir_q[b];
      assign pad_do[b] = dir_q[b] & out_q[b];
      assign pad_pu[b] = ~dir_q[b] & out_q[b];
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_do,
  output logic [WIDTH-1:0]  pad_pu
);
  logic [WIDTH-1:0] pin_val;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] out_q;

  gpio_sync #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(pad_in), .q_out(pin_val)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .pin_val(pin_val), .dir_q(dir_q), .out_q(out_q), .rd_data(rd_data)
  );

  gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
    .dir_q(dir_q), .out_q(out_q),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
  );

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_pu == '0 && pad_do == '0));

  // R5
  pu_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ((pad_pu & pad_oe) == '0));

  // R4
  in_do_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((pad_do & ~pad_oe) == '0));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] ext_a = '0, ext_b = '0;
  logic [W-1:0] rd_a, rd_b, oe_a, do_a, pu_a, oe_b, do_b, pu_b, pin_a, pin_b;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // pad models: loopback on outputs, pull-up on pulled inputs, else external
  assign pin_a = (oe_a & do_a) | (~oe_a & pu_a) | (~oe_a & ~pu_a & ext_a);
  assign pin_b = (oe_b & do_b) | (~oe_b & pu_b) | (~oe_b & ~pu_b & ext_b);

  gpio_port #(.WIDTH(W), .SYNC_STAGES(2)) u_gpio_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_a), .pad_in(pin_a), .pad_oe(oe_a), .pad_do(do_a), .pad_pu(pu_a)
  );

  gpio_port #(.WIDTH(W), .SYNC_STAGES(1)) u_gpio_port_s1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_b), .pad_in(pin_b), .pad_oe(oe_b), .pad_do(do_b), .pad_pu(pu_b)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] va, output logic [W-1:0] vb);
    addr = a; #1;
    va = rd_a; vb = rd_b;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [W-1:0] a, b;
    check("R1 oe", oe_a | oe_b, '0);
    check("R1 do", do_a | do_b, '0);
    check("R1 pu", pu_a | pu_b, '0);
    rd(2'd1, a, b); check("R1 dir read", a | b, '0);
    rd(2'd2, a, b); check("R1 out read", a | b, '0);
  endtask

  task automatic t_regs;
    logic [W-1:0] a, b;
    wr(2'd1, 8'h3C);
    rd(2'd1, a, b); check("R2 dir rd", a, 8'h3C);
    check("R3 oe", oe_a, 8'h3C);
    wr(2'd2, 8'hA5);
    rd(2'd2, a, b); check("R2 out rd", b, 8'hA5);
    check("R4 do", do_a, 8'h24);
    check("R5 pu", pu_a, 8'h81);
    check("R5 excl", pu_a & oe_a, '0);
  endtask

  task automatic t_ignored;
    logic [W-1:0] a, b;
    wr(2'd0, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd1, a, b); check("R7 dir kept", a, 8'h3C);
    rd(2'd2, a, b); check("R7 out kept", a, 8'hA5);
    rd(2'd3, a, b); check("R7 rsv reads 0", a | b, '0);
    check("R7 oe kept", oe_a, 8'h3C);
  endtask

  task automatic t_input_sync;
    logic [W-1:0] a, b;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    edges(3);
    @(negedge clk); ext_a = 8'h5A; ext_b = 8'h5A;
    edges(1);
    rd(2'd0, a, b);
    check("R6 two-stage not yet", a, 8'h00);
    check("R6 one-stage seen", b, 8'h5A);
    edges(1);
    rd(2'd0, a, b);
    check("R6 two-stage seen", a, 8'h5A);
  endtask

  task automatic t_mixed;
    logic [W-1:0] a, b;
    // bits 7..4 outputs driving 1010, bits 3..2 pulled-up inputs, bits 1..0 floating inputs
    wr(2'd1, 8'hF0);
    wr(2'd2, 8'hAC);
    @(negedge clk); ext_a = 8'h01; ext_b = 8'h01;
    edges(3);
    check("R8 oe", oe_a, 8'hF0);
    check("R8 do", do_a, 8'hA0);
    check("R8 pu", pu_a, 8'h0C);
    rd(2'd0, a, b);
    check("R8 pin mix", a, 8'hAD);
    check("R8 pin mix s1", b, 8'hAD);
  endtask

  task automatic t_loopback;
    logic [W-1:0] a, b;
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h00);
    edges(3);
    wr(2'd2, 8'h69);
    rd(2'd0, a, b);
    check("R9 s1 before clock", b, 8'h00);
    edges(1);
    rd(2'd0, a, b);
    check("R9 s1 one clock later", b, 8'h69);
    check("R6 s2 still old", a, 8'h00);
    edges(1);
    rd(2'd0, a, b);
    check("R9 s2 loopback", a, 8'h69);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    edges(3);
    @(negedge clk); rst = 1'b0;
    #1;
    t_reset();
    t_regs();
    t_ignored();
    t_input_sync();
    t_mixed();
    t_loopback();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule